// File: doc/BRIEF.md
# FEAC codeword serial transmitter

This block sends far-end alarm and control codewords on a low-rate serial overhead channel inside a framer. The host places one message byte, written as a zero, six message bits and a zero, into a holding register. At each codeword boundary the block moves a waiting byte into a 16-bit shift buffer and puts an all-ones flag octet in front of it. It then shifts the word out least-significant bit first, one bit for each bit-slot strobe from the framer. When the block accepts a byte it raises an interrupt. The host answers by writing the next byte, which may be the same byte again if the codeword is to repeat.

If no byte is waiting at a boundary, the block sends an all-ones idle codeword. A byte with a one in either outer bit counts as a request for idle. It is used up without being sent and without raising an interrupt, so idle continues until a correctly formed byte arrives. A codeword lasts 16 strobes. On a channel where that is about 1.7 ms, the host must write within that time after each interrupt to keep the stream unbroken. Repeat counting is left to the host.

Top module: `feac_tx`

## Requirements
- R1: After reset, ser_o is 1 and irq_pend_o, irq_o and hold_full_o are all 0.
- R2: A codeword is 16 bits, word[7:0] = 8'hFF and word[15:8] = the accepted byte, and it is sent bit 0 first, one bit per strobe.
- R3: ser_o takes a new value only in the cycle after a cycle with slot_i high, and it holds its value at all other times.
- R4: A write with wr_en_i sets hold_full_o in the next cycle. The held byte is moved out only at a codeword boundary, meaning the strobe that starts a codeword (every 16th strobe, counted from the first strobe after reset). hold_full_o then drops unless a write arrives in that same cycle.
- R5: irq_pend_o rises in the cycle after a boundary strobe that accepts a well-formed byte. Bit 7 and bit 0 must both be 0 for a byte to be well-formed.
- R6: A write clears irq_pend_o in the next cycle, unless an accept happens in the same cycle. In that case irq_pend_o stays set.
- R7: irq_o equals irq_pend_o when irq_en_i is 1 and is 0 when irq_en_i is 0.
- R8: If no byte is held at a boundary, the codeword sent is 16'hFFFF and irq_pend_o is unchanged.
- R9: A held byte with bit 7 or bit 0 set is used up at the boundary. An idle 16'hFFFF codeword goes out in its place and no interrupt is raised.
- R10: A write made while a codeword is being shifted does not disturb that codeword. If several writes arrive before the next boundary, the last one wins.
- R11: Rewriting the same byte on each interrupt sends the same codeword back to back with no idle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe for the message byte |
| wr_data_i | input | 8 | Message byte, form 0 m m m m m m 0 |
| slot_i | input | 1 | Single-cycle bit-slot strobe from the framer |
| irq_en_i | input | 1 | Interrupt enable for irq_o |
| ser_o | output | 1 | Serial overhead bit |
| hold_full_o | output | 1 | Holding register holds an unsent byte |
| irq_pend_o | output | 1 | Reload interrupt status |
| irq_o | output | 1 | Gated interrupt output |

## Verification
- **Slot counter out of step:** the flag octet lands in the wrong place in the serial stream, which shows within one 16-strobe codeword.
- **Accept logic error:** hold_full_o and irq_pend_o go wrong one cycle after the boundary strobe.
- **Malformed byte mishandled:** a malformed byte that is not dropped shows up as a non-idle word or a stray interrupt at the very next boundary.
- **Wrong write ordering:** a lost or overwritten write shows up as the wrong byte in the high half of the next word.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;
  localparam int unsigned FLAG_W_DEF = 8;
  localparam int unsigned MSG_W_DEF  = 8;
endpackage

// File: rtl/feac_hold_reg.sv
module feac_hold_reg #(
  parameter int unsigned MSG_W = feac_tx_pkg::MSG_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [MSG_W-1:0] wr_data_i,
  input  logic             take_i,
  output logic [MSG_W-1:0] data_o,
  output logic             full_o,
  output logic             accept_o,
  output logic             irq_pend_o
);
  logic [MSG_W-1:0] data_q;
  logic             full_q, pend_q, well_formed;

  assign well_formed = !data_q[MSG_W-1] && !data_q[0];
  assign accept_o    = take_i && full_q && well_formed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (wr_en_i) begin
      data_q <= wr_data_i;
      full_q <= 1'b1;
    end else if (take_i) begin
      full_q <= 1'b0;  // malformed bytes are consumed too
    end
  end

  // accept has priority over the clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (accept_o) pend_q <= 1'b1;
    else if (wr_en_i)  pend_q <= 1'b0;
  end

  assign data_o     = data_q;
  assign full_o     = full_q;
  assign irq_pend_o = pend_q;
endmodule

// File: rtl/feac_shifter.sv
module feac_shifter #(
  parameter int unsigned FLAG_W = feac_tx_pkg::FLAG_W_DEF,
  parameter int unsigned MSG_W  = feac_tx_pkg::MSG_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_i,
  input  logic             load_i,
  input  logic [MSG_W-1:0] msg_i,
  output logic             bound_o,
  output logic             ser_o
);
  localparam int unsigned CW_W  = FLAG_W + MSG_W;
  localparam int unsigned CNT_W = $clog2(CW_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CW_W-1:0]  sh_q, word;
  logic             ser_q;

  assign bound_o = slot_i && (cnt_q == '0);
  assign word    = load_i ? {msg_i, {FLAG_W{1'b1}}} : {CW_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      ser_q <= 1'b1;
    end else if (slot_i) begin
      cnt_q <= (cnt_q == CNT_W'(CW_W-1)) ? '0 : cnt_q + 1'b1;
      if (cnt_q == '0) begin
        ser_q <= word[0];
        sh_q  <= word >> 1;
      end else begin
        ser_q <= sh_q[0];
        sh_q  <= sh_q >> 1;  // buffer drains to zero by word end
      end
    end
  end

  assign ser_o = ser_q;
endmodule

// File: rtl/feac_tx.sv
module feac_tx #(
  parameter int unsigned FLAG_W = feac_tx_pkg::FLAG_W_DEF,
  parameter int unsigned MSG_W  = feac_tx_pkg::MSG_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [MSG_W-1:0] wr_data_i,
  input  logic             slot_i,
  input  logic             irq_en_i,
  output logic             ser_o,
  output logic             hold_full_o,
  output logic             irq_pend_o,
  output logic             irq_o
);
  logic             bound, accept;
  logic [MSG_W-1:0] held;

  feac_hold_reg #(.MSG_W(MSG_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .take_i     (bound),
    .data_o     (held),
    .full_o     (hold_full_o),
    .accept_o   (accept),
    .irq_pend_o (irq_pend_o)
  );

  feac_shifter #(.FLAG_W(FLAG_W), .MSG_W(MSG_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_i  (slot_i),
    .load_i  (accept),
    .msg_i   (held),
    .bound_o (bound),
    .ser_o   (ser_o)
  );

  assign irq_o = irq_pend_o && irq_en_i;
endmodule

// File: rtl/feac_tx_chk.sv
module feac_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic slot_i,
  input logic ser_o,
  input logic hold_full_o,
  input logic irq_pend_o,
  input logic irq_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_SER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(slot_i)) |-> $stable(ser_o)); // R3
  AST_FULL_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_en_i)) |-> hold_full_o); // R4
  AST_PEND_ON_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(irq_pend_o)) |-> ($past(slot_i) && $past(hold_full_o))); // R5
  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_en_i) && !$past(slot_i)) |-> !irq_pend_o); // R6
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_pend_o); // R7
endmodule

bind feac_tx feac_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .slot_i      (slot_i),
  .ser_o       (ser_o),
  .hold_full_o (hold_full_o),
  .irq_pend_o  (irq_pend_o),
  .irq_o       (irq_o)
);

// File: tb/feac_tx_bench.sv
module feac_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       slot = 1'b0;
  logic       irq_en = 1'b1;
  logic       ser, full, pend, irq;
  int         n_chk = 0;
  int         n_err = 0;
  logic [15:0] acc;
  int          pos = 0;
  logic [15:0] w;

  always #4 clk = ~clk;  // 125 MHz

  feac_tx u_feac_tx (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .slot_i      (slot),
    .irq_en_i    (irq_en),
    .ser_o       (ser),
    .hold_full_o (full),
    .irq_pend_o  (pend),
    .irq_o       (irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) slot = 1'b1;
    @(negedge clk) slot = 1'b0;
    acc[pos] = ser;
    pos = (pos + 1) % 16;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(ser == 1'b1 && pend == 1'b0 && irq == 1'b0 && full == 1'b0, "R1 reset",
        {ser, pend, irq, full}, 4'b1000);
    steps(16);
    chk(acc == 16'hFFFF, "R8 idle word after reset", acc, 16'hFFFF);
  endtask

  task automatic t_basic();
    logic s;
    write(8'h2A);
    chk(full == 1'b1, "R4 full after write", full, 1);
    chk(pend == 1'b0, "R5 no irq before boundary", pend, 0);
    strobe();
    chk(pend == 1'b1 && irq == 1'b1, "R5 irq on accept", {pend, irq}, 2'b11);
    chk(full == 1'b0, "R4 empty after transfer", full, 0);
    steps(4);
    s = ser;
    repeat (3) @(negedge clk);
    chk(ser == s, "R3 ser holds between strobes", ser, s);
    steps(11);
    chk(acc == 16'h2AFF, "R2 codeword format", acc, 16'h2AFF);
  endtask

  task automatic t_overwrite();
    strobe();
    chk(acc[0] == 1'b1, "R8 idle flag bit", acc[0], 1);
    write(8'h14);
    chk(pend == 1'b0, "R6 write clears irq", pend, 0);
    write(8'h3C);
    steps(15);
    chk(acc == 16'hFFFF, "R10 current word untouched", acc, 16'hFFFF);
    steps(16);
    chk(acc == 16'h3CFF, "R10 last write wins", acc, 16'h3CFF);
    chk(pend == 1'b1, "R5 irq after accept", pend, 1);
  endtask

  task automatic t_late_host();
    steps(16);
    chk(acc == 16'hFFFF, "R8 idle when host late", acc, 16'hFFFF);
    chk(pend == 1'b1, "R8 irq unchanged by idle", pend, 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq enabled", irq, 1);
  endtask

  task automatic t_malformed();
    write(8'h81);
    chk(pend == 1'b0, "R6 clear by malformed write", pend, 0);
    steps(16);
    chk(acc == 16'hFFFF && pend == 1'b0 && full == 1'b0, "R9 bit7|bit0 idle",
        {acc, pend, full}, {16'hFFFF, 2'b00});
    write(8'h01);
    steps(16);
    chk(acc == 16'hFFFF && pend == 1'b0, "R9 bit0 idle", {acc, pend}, {16'hFFFF, 1'b0});
    write(8'h82);
    steps(16);
    chk(acc == 16'hFFFF && pend == 1'b0, "R9 bit7 idle", {acc, pend}, {16'hFFFF, 1'b0});
  endtask

  task automatic t_repeat();
    write(8'h42);
    steps(1);
    chk(pend == 1'b1, "R11 irq on first copy", pend, 1);
    write(8'h42);
    steps(15);
    chk(acc == 16'h42FF, "R11 first copy", acc, 16'h42FF);
    steps(16);
    chk(acc == 16'h42FF, "R11 second copy back to back", acc, 16'h42FF);
  endtask

  task automatic t_same_cycle();
    write(8'h24);
    @(negedge clk) begin slot = 1'b1; wr_en = 1'b1; wr_data = 8'h18; end
    @(negedge clk) begin slot = 1'b0; wr_en = 1'b0; end
    acc[0] = ser;
    pos = 1;
    chk(pend == 1'b1, "R6 accept beats clear", pend, 1);
    chk(full == 1'b1, "R4 same-cycle write held", full, 1);
    steps(15);
    chk(acc == 16'h24FF, "R2 boundary word", acc, 16'h24FF);
    steps(16);
    chk(acc == 16'h18FF, "R4 held write sent next", acc, 16'h18FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overwrite();
    t_late_host();
    t_malformed();
    t_repeat();
    t_same_cycle();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule